// File: doc/BRIEF.md
# Multicast Descriptor Activation Engine

The engine turns a single index write into a train of unicast messages. Software writes a 6-bit set index while the engine is idle. The engine locates that descriptor set in memory from a programmable base address and fetches the set's first 64-byte descriptor over a simple read port. It then walks the descriptor's 256-bit destination vector and sends one message for each set bit. If a descriptor's chaining flag is set, the engine fetches the next descriptor in the set and continues the same activation.

Every message carries the descriptor payload, a destination node and a fixed sub-node value. The node is computed from the bit position: each step in the vector moves two node IDs. Responses from the far side come back on a plain response input. A three-bit status tells whether the activation is still running, finished cleanly, or ended with a particular fault.

The message output is valid/ready. Once `msg_valid` is high, the node and payload stay fixed until `msg_ready` is sampled high at a rising edge. The only exception is an activation that ends through the source timeout, which withdraws the offer. `msg_valid` does not depend on `msg_ready` within a cycle. The read request also uses valid/ready: `rd_valid` and `rd_addr` are held until `rd_ready`. Each request gets exactly one `rd_rvalid` pulse in a later cycle. At most one read is outstanding at a time.

Top module: `mcast_act_engine`

## Requirements
- R1: The descriptor at position d (0..7) of set n is read from address base_addr + n*512 + d*64. base_addr is captured when the index write is accepted.
- R2: A descriptor word is laid out as follows. Bits [255:0] hold the destination vector and bits [383:256] hold the 128-bit payload. Bits [511:384] hold the header: base node ID in header bits [14:0] (word bits 398:384) and the chaining flag in header bit 94 (word bit 478). The payload is copied unchanged into every message built from that descriptor.
- R3: The message for vector bit i has `msg_node` = (base node + 2*i) mod 2^15. `msg_subnode` is 5'h10 on every message.
- R4: Set bits are sent in ascending bit order, one message per cycle in which `msg_ready` is high. While `msg_valid` is high and `msg_ready` is low, the node and payload do not change.
- R5: After a descriptor's last message, the engine acts on the chaining flag. If the flag is 1, it fetches the next descriptor of the same set. If the flag is 1 on descriptor 7, no further fetch is made.
- R6: `status` uses three bits (error, busy, aux): 000 idle/clean, 010 busy, 100 far-side ack timeout, 101 strong reject, 110 source timeout, 111 far-side put failure. The values 001 and 011 never appear.
- R7: `status` reads 010 from the cycle after an accepted write until the vector walk is finished and every sent message has received a response. With no fault it then reads 000.
- R8: `rsp_code` is decoded as follows: 0 ok, 1 → 100, 2 → 101, 3 → 111. The first non-zero response of an activation fixes the final status, whatever responses arrive later.
- R9: The source timer starts at the first message handshake. If the activation is still busy when `tmo_limit` cycles have elapsed after that edge, the activation ends. The status becomes 110 in the second cycle after the limit is reached (22 cycles after the first handshake when the limit is 20), unless an earlier error response already fixed the code. No timer runs before the first message.
- R10: An index write while `status` is 010 is ignored: no fetch of the written set takes place and the current activation's messages are unchanged. It sets `overrun`, which stays high until reset.
- R11: A descriptor whose vector is all zeros sends no message. If it is unchained and nothing is outstanding, the activation ends at 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_addr | input | 40 | Byte address of set 0 |
| tmo_limit | input | 16 | Source timeout in cycles |
| act_wr | input | 1 | Index write strobe |
| act_idx | input | 6 | Set index |
| rd_valid | output | 1 | Descriptor read request |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 40 | Descriptor byte address |
| rd_rvalid | input | 1 | Read data returned |
| rd_rdata | input | 512 | Descriptor word |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message taken |
| msg_node | output | 15 | Destination node ID |
| msg_subnode | output | 5 | Destination sub-node, fixed 5'h10 |
| msg_payload | output | 128 | Descriptor payload |
| rsp_valid | input | 1 | One response for one sent message |
| rsp_code | input | 2 | Response result code |
| status | output | 3 | Activation status code |
| overrun | output | 1 | Sticky flag: write seen while busy |

## Verification
The assertions assume three things about the environment. Responses arrive only for messages already sent and in the order sent. Every read request is answered by exactly one data pulse. `base_addr` and `tmo_limit` change only while the engine is idle. The stimulus keeps to these rules by construction. A single bench loop counts handshakes and answers only that count, and a memory model returns one word per accepted request. Setup values are written only after status has left 010. The one deliberate departure is an index write during a busy activation.

// File: rtl/mdae_pkg.sv
package mdae_pkg;

  typedef enum logic [2:0] {
    ACT_IDLE      = 3'b000,
    ACT_BUSY      = 3'b010,
    ACT_ACK_TMO   = 3'b100,
    ACT_REJECT    = 3'b101,
    ACT_SRC_TMO   = 3'b110,
    ACT_PUT_FAIL  = 3'b111
  } act_status_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_REQ,
    PH_WAIT,
    PH_WALK,
    PH_DRAIN
  } phase_e;

  function automatic act_status_e rsp_to_status(input logic [1:0] code);
    case (code)
      2'd1:    return ACT_ACK_TMO;
      2'd2:    return ACT_REJECT;
      2'd3:    return ACT_PUT_FAIL;
      default: return ACT_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/mdae_addr_gen.sv
module mdae_addr_gen #(
  parameter int ADDR_W  = 40,
  parameter int IDX_W   = 6,
  parameter int DIDX_W  = 3,
  parameter int BYTE_LG = 6
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic [DIDX_W-1:0] desc_idx,
  output logic [ADDR_W-1:0] addr
);
  localparam int OFF_W = IDX_W + DIDX_W + BYTE_LG;

  logic [OFF_W-1:0] offset;

  assign offset = {set_idx, desc_idx, {BYTE_LG{1'b0}}};
  assign addr   = base + ADDR_W'(offset);
endmodule

// File: rtl/mdae_vec_walker.sv
module mdae_vec_walker #(
  parameter int VEC_W  = 256,
  parameter int NODE_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [VEC_W-1:0]  load_vec,
  input  logic [NODE_W-1:0] load_node,
  input  logic              take,
  input  logic              flush,
  output logic              any,
  output logic [NODE_W-1:0] node
);
  localparam int BIT_W = $clog2(VEC_W);

  logic [VEC_W-1:0]  vec_q;
  logic [NODE_W-1:0] node_q;
  logic [BIT_W-1:0]  cur_idx;

  always_comb begin
    cur_idx = '0;
    for (int i = VEC_W - 1; i >= 0; i--) begin
      if (vec_q[i]) cur_idx = BIT_W'(i);
    end
  end

  assign any  = |vec_q;
  assign node = node_q + NODE_W'({cur_idx, 1'b0});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      node_q <= '0;
    end else if (flush) begin
      vec_q <= '0;
    end else if (load) begin
      vec_q  <= load_vec;
      node_q <= load_node;
    end else if (take) begin
      vec_q[cur_idx] <= 1'b0;
    end
  end
endmodule

// File: rtl/mdae_status_trk.sv
module mdae_status_trk
  import mdae_pkg::*;
#(
  parameter int OUT_W = 12,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             issue,
  input  logic             rsp_valid,
  input  logic [1:0]       rsp_code,
  input  logic             walk_done,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             busy,
  output logic             finish,
  output logic [2:0]       status
);
  logic             busy_q;
  logic [OUT_W-1:0] outst_q;
  logic [OUT_W-1:0] outst_nx;
  act_status_e      err_q;
  act_status_e      err_nx;
  act_status_e      final_q;
  logic             started_q;
  logic [TMO_W-1:0] tcnt_q;
  logic             rsp_take;
  logic             tmo_hit;
  logic             done_hit;

  assign rsp_take = busy_q && rsp_valid && (outst_q != '0);
  assign outst_nx = outst_q + OUT_W'(issue) - OUT_W'(rsp_take);

  always_comb begin
    err_nx = err_q;
    if (rsp_take && (rsp_code != 2'd0) && (err_q == ACT_IDLE))
      err_nx = rsp_to_status(rsp_code);
  end

  assign tmo_hit  = busy_q && started_q && (tcnt_q >= tmo_limit);
  assign done_hit = busy_q && walk_done && (outst_nx == '0);
  assign finish   = tmo_hit || done_hit;
  assign busy     = busy_q;
  assign status   = busy_q ? ACT_BUSY : final_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      outst_q   <= '0;
      err_q     <= ACT_IDLE;
      final_q   <= ACT_IDLE;
      started_q <= 1'b0;
      tcnt_q    <= '0;
    end else if (start) begin
      busy_q    <= 1'b1;
      outst_q   <= '0;
      err_q     <= ACT_IDLE;
      started_q <= 1'b0;
      tcnt_q    <= '0;
    end else if (busy_q) begin
      outst_q <= outst_nx;
      err_q   <= err_nx;
      if (issue && !started_q) begin
        started_q <= 1'b1;
        tcnt_q    <= '0;
      end else if (started_q) begin
        tcnt_q <= tcnt_q + 1'b1;
      end
      if (tmo_hit) begin
        busy_q  <= 1'b0;
        final_q <= (err_nx != ACT_IDLE) ? err_nx : ACT_SRC_TMO;
      end else if (done_hit) begin
        busy_q  <= 1'b0;
        final_q <= err_nx;
      end
    end
  end
endmodule

// File: rtl/mcast_act_engine.sv
module mcast_act_engine
  import mdae_pkg::*;
#(
  parameter int ADDR_W       = 40,
  parameter int IDX_W        = 6,
  parameter int DESC_PER_SET = 8,
  parameter int VEC_W        = 256,
  parameter int PAY_W        = 128,
  parameter int HDR_W        = 128,
  parameter int NODE_W       = 15,
  parameter int TMO_W        = 16,
  parameter int CHAIN_BIT    = 94,
  parameter int SUB_W        = 5,
  parameter logic [SUB_W-1:0] SUBNODE = 5'h10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             base_addr,
  input  logic [TMO_W-1:0]              tmo_limit,
  input  logic                          act_wr,
  input  logic [IDX_W-1:0]              act_idx,
  output logic                          rd_valid,
  input  logic                          rd_ready,
  output logic [ADDR_W-1:0]             rd_addr,
  input  logic                          rd_rvalid,
  input  logic [VEC_W+PAY_W+HDR_W-1:0]  rd_rdata,
  output logic                          msg_valid,
  input  logic                          msg_ready,
  output logic [NODE_W-1:0]             msg_node,
  output logic [SUB_W-1:0]              msg_subnode,
  output logic [PAY_W-1:0]              msg_payload,
  input  logic                          rsp_valid,
  input  logic [1:0]                    rsp_code,
  output logic [2:0]                    status,
  output logic                          overrun
);
  localparam int DESC_W  = VEC_W + PAY_W + HDR_W;
  localparam int DIDX_W  = $clog2(DESC_PER_SET);
  localparam int BYTE_LG = $clog2(DESC_W / 8);
  localparam int OUT_W   = $clog2(VEC_W * DESC_PER_SET + 1);
  localparam int PAY_LO  = VEC_W;
  localparam int HDR_LO  = VEC_W + PAY_W;
  localparam logic [DIDX_W-1:0] LAST_DESC = DIDX_W'(DESC_PER_SET - 1);

  phase_e            phase_q;
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  set_q;
  logic [DIDX_W-1:0] desc_q;
  logic              chain_q;
  logic [PAY_W-1:0]  pay_q;
  logic              overrun_q;

  logic busy;
  logic finish;
  logic accept;
  logic w_load;
  logic w_any;
  logic take;

  assign accept = act_wr && !busy;
  assign w_load = (phase_q == PH_WAIT) && rd_rvalid;
  assign take   = msg_valid && msg_ready;

  mdae_addr_gen #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .DIDX_W (DIDX_W),
    .BYTE_LG(BYTE_LG)
  ) u_addr (
    .base    (base_q),
    .set_idx (set_q),
    .desc_idx(desc_q),
    .addr    (rd_addr)
  );

  mdae_vec_walker #(
    .VEC_W (VEC_W),
    .NODE_W(NODE_W)
  ) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (w_load),
    .load_vec (rd_rdata[VEC_W-1:0]),
    .load_node(rd_rdata[HDR_LO +: NODE_W]),
    .take     (take),
    .flush    (finish),
    .any      (w_any),
    .node     (msg_node)
  );

  mdae_status_trk #(
    .OUT_W(OUT_W),
    .TMO_W(TMO_W)
  ) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .issue    (take),
    .rsp_valid(rsp_valid),
    .rsp_code (rsp_code),
    .walk_done(phase_q == PH_DRAIN),
    .tmo_limit(tmo_limit),
    .busy     (busy),
    .finish   (finish),
    .status   (status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      base_q    <= '0;
      set_q     <= '0;
      desc_q    <= '0;
      chain_q   <= 1'b0;
      pay_q     <= '0;
      overrun_q <= 1'b0;
    end else begin
      if (act_wr && busy) overrun_q <= 1'b1;
      if (finish) begin
        phase_q <= PH_IDLE;
      end else begin
        case (phase_q)
          PH_IDLE: if (accept) begin
            phase_q <= PH_REQ;
            set_q   <= act_idx;
            base_q  <= base_addr;
            desc_q  <= '0;
          end
          PH_REQ: if (rd_ready) phase_q <= PH_WAIT;
          PH_WAIT: if (rd_rvalid) begin
            phase_q <= PH_WALK;
            pay_q   <= rd_rdata[PAY_LO +: PAY_W];
            chain_q <= rd_rdata[HDR_LO + CHAIN_BIT];
          end
          PH_WALK: if (!w_any) begin
            if (chain_q && (desc_q != LAST_DESC)) begin
              desc_q  <= desc_q + 1'b1;
              phase_q <= PH_REQ;
            end else begin
              phase_q <= PH_DRAIN;
            end
          end
          PH_DRAIN: phase_q <= PH_DRAIN;
          default:  phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign rd_valid    = (phase_q == PH_REQ);
  assign msg_valid   = (phase_q == PH_WALK) && w_any;
  assign msg_subnode = SUBNODE;
  assign msg_payload = pay_q;
  assign overrun     = overrun_q;
endmodule

// File: rtl/mdae_checker.sv
module mdae_checker #(
  parameter int NODE_W = 15,
  parameter int PAY_W  = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              act_wr,
  input logic              rd_valid,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [NODE_W-1:0] msg_node,
  input logic [PAY_W-1:0]  msg_payload,
  input logic [2:0]        status,
  input logic              overrun
);
  // R6: the two unused codes never reach the status port
  assert_status_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 3'b001) && (status != 3'b011));

  // R4: an offered message is held until it is taken (unless the activation ends)
  assert_msg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=>
      ((status != 3'b010) || (msg_valid && $stable(msg_node) && $stable(msg_payload))));

  // R7: messages are offered only inside a busy activation
  assert_msg_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (status == 3'b010));

  // R1: descriptor reads are issued only inside a busy activation
  assert_fetch_in_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (status == 3'b010));

  // R10: the overrun flag never clears outside reset
  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R10: the flag rises only after a write that met a busy engine
  assert_overrun_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> ($past(act_wr) && ($past(status) == 3'b010)));
endmodule

bind mcast_act_engine mdae_checker #(
  .NODE_W(NODE_W),
  .PAY_W (PAY_W)
) u_mdae_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .act_wr     (act_wr),
  .rd_valid   (rd_valid),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_node   (msg_node),
  .msg_payload(msg_payload),
  .status     (status),
  .overrun    (overrun)
);

// File: tb/tb_mcast_act_engine.sv
`timescale 1ns/1ps
module tb_mcast_act_engine;
  localparam int ADDR_W = 40;
  localparam int IDX_W  = 6;
  localparam int VEC_W  = 256;
  localparam int PAY_W  = 128;
  localparam int NODE_W = 15;
  localparam int TMO_W  = 16;
  localparam int DESC_W = 512;
  localparam int MAXM   = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [ADDR_W-1:0] base_addr = '0;
  logic [TMO_W-1:0]  tmo_limit = '1;
  logic              act_wr = 1'b0;
  logic [IDX_W-1:0]  act_idx = '0;
  logic              rd_valid;
  logic              rd_ready = 1'b1;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_rvalid = 1'b0;
  logic [DESC_W-1:0] rd_rdata = '0;
  logic              msg_valid;
  logic              msg_ready = 1'b1;
  logic [NODE_W-1:0] msg_node;
  logic [4:0]        msg_subnode;
  logic [PAY_W-1:0]  msg_payload;
  logic              rsp_valid = 1'b0;
  logic [1:0]        rsp_code = 2'd0;
  logic [2:0]        status;
  logic              overrun;

  mcast_act_engine dut (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .tmo_limit(tmo_limit),
    .act_wr(act_wr), .act_idx(act_idx), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_node(msg_node),
    .msg_subnode(msg_subnode), .msg_payload(msg_payload), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .status(status), .overrun(overrun)
  );

  int n_chk = 0;
  int n_err = 0;

  // descriptor set image and expectations
  logic [VEC_W-1:0]  dvec   [8];
  logic [NODE_W-1:0] dnode  [8];
  logic              dchain [8];
  logic [PAY_W-1:0]  dpay   [8];
  logic [NODE_W-1:0] exp_node [MAXM];
  logic [PAY_W-1:0]  exp_pay  [MAXM];
  int exp_n = 0;
  int exp_fetch = 0;
  logic [ADDR_W-1:0] exp_set_addr = '0;

  int msg_seen = 0;
  int fetch_seen = 0;
  int pend = 0;
  int rsp_sent = 0;
  int rsp_limit = 1 << 20;
  bit rsp_gap = 1'b0;
  bit rdy_rand = 1'b0;
  int err_at0 = -1, err_at1 = -1;
  logic [1:0] err_c0 = 2'd0, err_c1 = 2'd0;
  int cyc = 0;
  int first_cyc = 0;
  int done_cyc = 0;
  bit prev_busy = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] code_map(input logic [1:0] c);
    case (c)
      2'd1: return 3'b100;
      2'd2: return 3'b101;
      2'd3: return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [1:0] code_of(input int k);
    if (k == err_at0) return err_c0;
    if (k == err_at1) return err_c1;
    return 2'd0;
  endfunction

  task automatic build_expect();
    int d;
    exp_n = 0;
    exp_fetch = 0;
    d = 0;
    forever begin
      exp_fetch++;
      for (int i = 0; i < VEC_W; i++) begin
        if (dvec[d][i]) begin
          exp_node[exp_n] = NODE_W'(dnode[d] + NODE_W'(2 * i));
          exp_pay[exp_n]  = dpay[d];
          exp_n++;
        end
      end
      if (dchain[d] && d < 7) d++;
      else break;
    end
  endtask

  task automatic clear_set();
    for (int d = 0; d < 8; d++) begin
      dvec[d] = '0; dnode[d] = '0; dchain[d] = 1'b0; dpay[d] = '0;
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // memory model: one data pulse per accepted read (checks R1/R5 addressing)
  initial begin
    forever begin
      @(negedge clk);
      rd_rvalid = 1'b0;
      if (rd_valid) begin
        int f;
        logic [127:0] h;
        f = fetch_seen;
        check(rd_addr == exp_set_addr + ADDR_W'(64 * f), "R1", "descriptor address",
              128'(rd_addr), 128'(exp_set_addr + ADDR_W'(64 * f)));
        fetch_seen++;
        if (f > 7) f = 0;
        h = '0;
        h[14:0] = dnode[f];
        h[94]   = dchain[f];
        @(negedge clk);
        rd_rvalid = 1'b1;
        rd_rdata  = {h, dpay[f], dvec[f]};
      end
    end
  end

  // stream loop: responses, ready pattern, message checks
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if ((status != 3'b010) && prev_busy) done_cyc = cyc;
      prev_busy = (status == 3'b010);
      rsp_valid = 1'b0;
      if (pend > 0 && rsp_sent < rsp_limit && (!rsp_gap || (cyc % 3 == 0))) begin
        rsp_valid = 1'b1;
        rsp_code  = code_of(rsp_sent);
        rsp_sent++;
        pend--;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      msg_ready = rdy_rand ? lfsr[0] : 1'b1;
      if (msg_valid && msg_ready) begin
        if (msg_seen < exp_n) begin
          check(msg_node == exp_node[msg_seen], "R3", "node",
                128'(msg_node), 128'(exp_node[msg_seen]));
          check(msg_subnode == 5'h10, "R3", "subnode", 128'(msg_subnode), 128'h10);
          check(msg_payload == exp_pay[msg_seen], "R2", "payload",
                msg_payload, exp_pay[msg_seen]);
        end else begin
          check(1'b0, "R4", "extra message", 128'(msg_seen), 128'(exp_n));
        end
        if (msg_seen == 0) first_cyc = cyc;
        msg_seen++;
        pend++;
      end
    end
  end

  task automatic run_act(input logic [IDX_W-1:0] idx, input logic [ADDR_W-1:0] base,
                         input logic [TMO_W-1:0] tmo, input logic [2:0] exp_st,
                         input bit poke, input string req);
    int k;
    step();
    base_addr = base;
    tmo_limit = tmo;
    build_expect();
    exp_set_addr = base + ADDR_W'({idx, 9'b0});
    msg_seen = 0; fetch_seen = 0; pend = 0; rsp_sent = 0;
    act_wr = 1'b1; act_idx = idx;
    step();
    act_wr = 1'b0;
    if (poke) begin
      step();
      act_wr = 1'b1; act_idx = idx ^ 6'h01;
      step();
      act_wr = 1'b0;
    end
    k = 0;
    while (status == 3'b010 && k < 20000) begin
      step();
      k++;
    end
    check(status == exp_st, req, "final status", 128'(status), 128'(exp_st));
    check(msg_seen == exp_n, "R4", "message count", 128'(msg_seen), 128'(exp_n));
    check(fetch_seen == exp_fetch, "R5", "fetch count", 128'(fetch_seen), 128'(exp_fetch));
    if (exp_st != 3'b110 && rsp_limit > exp_n)
      check(pend == 0, "R7", "all responses consumed", 128'(pend), 128'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    clear_set();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    step();
    // reset state (R6, R10)
    check(status == 3'b000, "R6", "reset status", 128'(status), 128'h0);
    check(msg_valid == 1'b0, "R4", "reset msg_valid", 128'(msg_valid), 128'h0);
    check(rd_valid == 1'b0, "R1", "reset rd_valid", 128'(rd_valid), 128'h0);
    check(overrun == 1'b0, "R10", "reset overrun", 128'(overrun), 128'h0);

    // R1 sweep over every set index, aligned and unaligned bases
    for (int s = 0; s < 64; s++) begin
      clear_set();
      dvec[0][(s * 5) % 256] = 1'b1;
      dnode[0] = NODE_W'(s * 517);
      dpay[0]  = {4{32'(s) ^ 32'h5A5A0000}};
      run_act(IDX_W'(s), (s % 2 == 1) ? 40'h12_3456_789A : 40'h80_0000_0000,
              16'd1000, 3'b000, 1'b0, "R1");
    end

    // R3 wrap, R4 ordering under random ready, R7 with gapped responses, R5 chain
    clear_set();
    dvec[0] = '1;           dnode[0] = 15'h7FF0; dchain[0] = 1'b1; dpay[0] = {4{32'hDEADBEEF}};
    dvec[1] = {1'b1, 254'b0, 1'b1}; dnode[1] = 15'd3; dchain[1] = 1'b1; dpay[1] = 128'h1;
    dvec[2] = {32{8'hA5}};  dnode[2] = 15'h1234; dpay[2] = {8{16'hC0DE}};
    rdy_rand = 1'b1; rsp_gap = 1'b1;
    run_act(6'd9, 40'h00_4000_0200, 16'd60000, 3'b000, 1'b0, "R7");
    rdy_rand = 1'b0; rsp_gap = 1'b0;

    // R5: chain flag on every descriptor including the last one
    clear_set();
    for (int d = 0; d < 8; d++) begin
      dvec[d][d * 31 + 1] = 1'b1;
      dvec[d][255] = 1'b1;
      dnode[d] = NODE_W'(d * 100);
      dchain[d] = 1'b1;
      dpay[d] = 128'(d + 7);
    end
    run_act(6'd63, 40'h01_0000_0000, 16'd1000, 3'b000, 1'b0, "R5");

    // R11: empty unchained descriptor
    clear_set();
    run_act(6'd5, 40'h00_0000_1000, 16'd1000, 3'b000, 1'b0, "R11");

    // R11 with R5: empty descriptor chained to a populated one
    clear_set();
    dchain[0] = 1'b1;
    dvec[1][0] = 1'b1; dvec[1][200] = 1'b1; dnode[1] = 15'd50; dpay[1] = 128'hABC;
    run_act(6'd7, 40'h00_0000_1000, 16'd1000, 3'b000, 1'b0, "R11");

    // R8: each response code maps to its status
    for (int c = 1; c < 4; c++) begin
      clear_set();
      dvec[0][17] = 1'b1; dnode[0] = 15'd4;
      err_at0 = 0; err_c0 = 2'(c);
      run_act(6'd2, 40'h00_0000_0000, 16'd1000, code_map(2'(c)), 1'b0, "R8");
    end

    // R8: first error wins
    clear_set();
    dvec[0][4:0] = 5'b11111; dnode[0] = 15'd10;
    err_at0 = 1; err_c0 = 2'd2; err_at1 = 3; err_c1 = 2'd1;
    run_act(6'd3, 40'h00_0000_0000, 16'd1000, 3'b101, 1'b0, "R8");
    err_at0 = 3; err_c0 = 2'd2; err_at1 = 1; err_c1 = 2'd3;
    run_act(6'd3, 40'h00_0000_0000, 16'd1000, 3'b111, 1'b0, "R8");
    err_at0 = -1; err_at1 = -1;

    // R9: source timeout at the exact cycle, no responses at all
    clear_set();
    dvec[0][2:0] = 3'b111; dnode[0] = 15'd20;
    rsp_limit = 0;
    run_act(6'd11, 40'h00_0000_0000, 16'd20, 3'b110, 1'b0, "R9");
    check(done_cyc - first_cyc == 22, "R9", "timeout latency",
          128'(done_cyc - first_cyc), 128'd22);

    // R9 with R8: an earlier error keeps its code through the timeout
    rsp_limit = 1; err_at0 = 0; err_c0 = 2'd2;
    run_act(6'd11, 40'h00_0000_0000, 16'd20, 3'b101, 1'b0, "R9");
    err_at0 = -1;

    // R10: write during busy is ignored and sets the sticky flag
    rsp_limit = 0;
    run_act(6'd12, 40'h00_0000_0000, 16'd40, 3'b110, 1'b1, "R10");
    check(overrun == 1'b1, "R10", "overrun set", 128'(overrun), 128'h1);
    rsp_limit = 1 << 20;
    run_act(6'd13, 40'h00_0000_0000, 16'd40, 3'b000, 1'b0, "R10");
    check(overrun == 1'b1, "R10", "overrun sticky", 128'(overrun), 128'h1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule